// File: doc/BRIEF.md
# Oversampling Serial Receiver with Parity

This block recovers 8-bit characters from an asynchronous serial line whose idle level is high. The raw line first passes through a chain of synchronizing flops. A falling edge on the synchronized line, seen while the receiver is idle, starts a frame. The receiver then runs on an oversample tick at sixteen times the bit rate and takes each bit at its centre.

The tick period comes from a 16-bit runtime divisor, rounded to the nearest multiple of sixteen. A divisor of zero selects a built-in default. Parity can be off, even or odd. The divisor and the two parity controls are captured at the start edge of each frame, so a change made during a frame does not affect that frame.

A completed frame produces a one-cycle valid pulse with the byte on the data output. If the stop bit was low or the parity bit did not match, a one-cycle error pulse fires in the same cycle as the valid pulse, and the byte is still presented. A start bit that is high again at its centre is treated as noise: the receiver goes back to idle and produces no output.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, the valid and error outputs are low and the data output is 0x00.
- R2: A frame is one low start bit, 8 data bits sent LSB first, an optional parity bit, and one high stop bit. When the stop bit is sampled, the receiver presents the byte and pulses valid.
- R3: The oversample period, in clocks, is the divisor divided by 16 and rounded to the nearest integer, so one bit lasts 16 times that period. A divisor of 24 gives 32 clocks per bit, a divisor of 23 gives 16, and the smallest divisor, 16, gives 16 clocks per bit.
- R4: A divisor of 0 acts as a divisor of 434, which gives 27 clocks per oversample tick and 432 clocks per bit.
- R5: When parity is enabled, a parity bit follows bit 7 of the data. With parity_odd low, the data bits plus the parity bit hold an even number of ones. With parity_odd high, they hold an odd number of ones.
- R6: A parity mismatch raises the error output in the same cycle as valid, and the received byte is still presented.
- R7: A low stop bit raises the error output in the same cycle as valid, and the received byte is still presented.
- R8: The divisor, parity_en and parity_odd are captured at the start edge. A change to any of them during a frame does not affect that frame.
- R9: If the line is high again at the middle of the start bit, the frame is dropped and no valid pulse is produced. The next proper frame is received normally.
- R10: Frames are received correctly when the sender's bit rate is 4% faster or 4% slower than the programmed rate.
- R11: Valid and error each last exactly one cycle, and error never goes high without valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Raw asynchronous serial line, idles high |
| divisor | input | 16 | Clocks per bit; 0 selects the default of 434 |
| parity_en | input | 1 | Expect a parity bit after the data bits |
| parity_odd | input | 1 | Odd parity when high, even parity when low |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |
| rx_err | output | 1 | One-cycle pulse with valid when the frame had a framing or parity error |

## Verification
Frame completion and error detection are both decided when the stop bit is sampled, so valid and error can pulse in the same cycle. The bench provokes this in two ways: it inverts the parity bit, and it drives the stop bit low, in frames both with and without parity. It then requires a single valid pulse that carries the transmitted byte together with the error pulse. A monitor sampling on the falling clock edge reports any error pulse that arrives without valid, and any valid pulse that lasts longer than one cycle.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

    localparam int DIV_W   = 16;
    localparam int DATA_W  = 8;
    localparam int OS_RATE = 16;
    localparam int OS_SH   = $clog2(OS_RATE);
    localparam int PER_W   = DIV_W - OS_SH + 1;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic             par_en;
        logic             par_odd;
        logic [PER_W-1:0] period;
    } rx_cfg_t;

    // Oversample period: divisor / OS_RATE rounded to nearest, at least 1.
    function automatic logic [PER_W-1:0] os_period(input logic [DIV_W-1:0] div);
        logic [DIV_W:0]   sum;
        logic [PER_W-1:0] p;
        sum = {1'b0, div} + (DIV_W+1)'(OS_RATE / 2);
        p   = PER_W'(sum >> OS_SH);
        if (p == '0) p = PER_W'(1);
        return p;
    endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("uart_os_rx_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/uart_os_rx_tick.sv
module uart_os_rx_tick
    import uart_os_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic [PER_W-1:0] period_i,
    output logic             tick_o
);
    logic [PER_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (restart_i)      cnt <= period_i - PER_W'(1);
        else if (cnt == '0)      cnt <= period_i - PER_W'(1);
        else                     cnt <= cnt - PER_W'(1);
    end

    assign tick_o = (cnt == '0);

    // R3: after a tick the counter restarts a full period
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !restart_i) |=> (cnt == $past(period_i) - PER_W'(1)));
endmodule

// File: rtl/uart_os_rx_core.sv
module uart_os_rx_core
    import uart_os_rx_pkg::*;
#(
    parameter int DEFAULT_DIV = 434
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              tick_i,
    output logic              restart_o,
    output logic [PER_W-1:0]  period_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int OS_W     = $clog2(OS_RATE);
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int OS_LAST  = OS_RATE - 1;
    localparam int MID_LAST = OS_RATE / 2 - 1;

    rx_state_e         state;
    rx_cfg_t           cfg, cfg_new;
    logic              line_q;
    logic [OS_W-1:0]   os_cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc, par_bad;
    logic              fall, last_os;

    assign fall      = line_q & ~line_i;
    assign restart_o = (state == RX_IDLE) && fall;
    assign last_os   = tick_i && (os_cnt == OS_W'(OS_LAST));

    always_comb begin
        cfg_new.par_en  = par_en_i;
        cfg_new.par_odd = par_odd_i;
        cfg_new.period  = os_period((div_i == '0) ? DIV_W'(DEFAULT_DIV) : div_i);
    end

    assign period_o = restart_o ? cfg_new.period : cfg.period;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cfg     <= '0;
            line_q  <= 1'b1;
            os_cnt  <= '0;
            idx     <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            par_bad <= 1'b0;
            data_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            line_q  <= line_i;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            if (state != RX_IDLE && state != RX_START && tick_i)
                os_cnt <= last_os ? '0 : os_cnt + OS_W'(1);
            unique case (state)
                RX_IDLE: if (fall) begin
                    cfg     <= cfg_new;
                    os_cnt  <= '0;
                    idx     <= '0;
                    par_acc <= 1'b0;
                    par_bad <= 1'b0;
                    state   <= RX_START;
                end
                RX_START: if (tick_i) begin
                    if (os_cnt == OS_W'(MID_LAST)) begin
                        os_cnt <= '0;
                        state  <= line_i ? RX_IDLE : RX_DATA;
                    end else begin
                        os_cnt <= os_cnt + OS_W'(1);
                    end
                end
                RX_DATA: if (last_os) begin
                    shreg   <= {line_i, shreg[DATA_W-1:1]};
                    par_acc <= par_acc ^ line_i;
                    idx     <= idx + IDX_W'(1);
                    if (idx == IDX_W'(DATA_W - 1))
                        state <= cfg.par_en ? RX_PARITY : RX_STOP;
                end
                RX_PARITY: if (last_os) begin
                    par_bad <= par_acc ^ line_i ^ cfg.par_odd;
                    state   <= RX_STOP;
                end
                RX_STOP: if (last_os) begin
                    data_o  <= shreg;
                    valid_o <= 1'b1;
                    err_o   <= ~line_i | par_bad;
                    state   <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R11: error only accompanies a valid pulse
    p_err_with_valid_r11: assert property (@(posedge clk) disable iff (rst)
        err_o |-> valid_o);
    // R11: valid lasts a single cycle
    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    // R2: a result appears only after the stop bit state
    p_valid_after_stop_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(state) == RX_STOP);
    // R8: captured configuration holds for the whole frame
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state != RX_IDLE && $past(state) != RX_IDLE) |-> $stable(cfg));
    // R9: a start bit high at its centre drops the frame
    p_glitch_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && tick_i && os_cnt == OS_W'(MID_LAST) && line_i)
        |=> (state == RX_IDLE && !valid_o));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEFAULT_DIV = 434
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              parity_en,
    input  logic              parity_odd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_err
);
    logic             line_s, tick, restart;
    logic [PER_W-1:0] period;

    uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .d_i (rx_line), .q_o (line_s)
    );

    uart_os_rx_tick u_tick (
        .clk (clk), .rst (rst), .restart_i (restart),
        .period_i (period), .tick_o (tick)
    );

    uart_os_rx_core #(.DEFAULT_DIV(DEFAULT_DIV)) u_core (
        .clk (clk), .rst (rst), .line_i (line_s), .div_i (divisor),
        .par_en_i (parity_en), .par_odd_i (parity_odd), .tick_i (tick),
        .restart_o (restart), .period_o (period),
        .data_o (rx_data), .valid_o (rx_valid), .err_o (rx_err)
    );
endmodule

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic [15:0] divisor = 16'd16;
    logic        parity_en = 1'b0;
    logic        parity_odd = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_err;

    int checks = 0, fails = 0;
    int vcount = 0, bad_err = 0, bad_pulse = 0;
    logic [7:0] last_data = 8'h00;
    logic       last_err = 1'b0, prev_v = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    uart_os_rx dut_i (
        .clk (clk), .rst (rst), .rx_line (rx_line), .divisor (divisor),
        .parity_en (parity_en), .parity_odd (parity_odd),
        .rx_data (rx_data), .rx_valid (rx_valid), .rx_err (rx_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                vcount++;
                last_data = rx_data;
                last_err  = rx_err;
            end
            if (rx_err && !rx_valid) bad_err++;
            if (rx_valid && prev_v)  bad_pulse++;
            prev_v = rx_valid;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bit_clocks(input int div);
        int d = (div == 0) ? 434 : div;
        int p = (d + 8) / 16;
        if (p == 0) p = 1;
        return 16 * p;
    endfunction

    // mode: 0 none, 1 even, 2 odd
    task automatic send(input logic [7:0] d, input int mode, input bit flip,
                        input bit stop_v, input real bitlen);
        logic bits [0:10];
        int n, elapsed, target;
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[i+1] = d[i];
        n = 9;
        if (mode != 0) begin
            bits[n] = ((mode == 2) ? ~(^d) : (^d)) ^ flip;
            n++;
        end
        bits[n] = stop_v;
        n++;
        elapsed = 0;
        for (int i = 0; i < n; i++) begin
            rx_line = bits[i];
            target = $rtoi((i + 1) * bitlen + 0.5);
            while (elapsed < target) begin
                @(negedge clk);
                elapsed++;
            end
        end
        rx_line = 1'b1;
        repeat ($rtoi(bitlen) + 4) @(negedge clk);
    endtask

    task automatic expect_frame(input string tag, input logic [7:0] d, input int mode,
                                input bit flip, input bit stop_v, input real bitlen);
        int  v0 = vcount;
        bit  exp_err = ((mode != 0) && flip) || !stop_v;
        send(d, mode, flip, stop_v, bitlen);
        chk(vcount == v0 + 1, {tag, " valid count"}, vcount - v0, 1);
        chk(last_data == d, {tag, " data"}, last_data, d);
        chk(last_err == exp_err, {tag, " error"}, last_err, exp_err);
    endtask

    task automatic setcfg(input int div, input int mode);
        divisor    = 16'(div);
        parity_en  = (mode != 0);
        parity_odd = (mode == 2);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rx_valid == 1'b0, "R1 valid after reset", rx_valid, 0);
        chk(rx_err == 1'b0, "R1 error after reset", rx_err, 0);
        chk(rx_data == 8'h00, "R1 data after reset", rx_data, 0);

        // R2 / R3 minimum divisor, plain frames
        setcfg(16, 0);
        expect_frame("R2 byte 00", 8'h00, 0, 0, 1, bit_clocks(16));
        expect_frame("R2 byte FF", 8'hFF, 0, 0, 1, bit_clocks(16));
        expect_frame("R2 byte 01 LSB first", 8'h01, 0, 0, 1, bit_clocks(16));
        expect_frame("R3 min divisor A5", 8'hA5, 0, 0, 1, 16.0);

        // R3 rounding: 24 -> 32 clocks per bit, 23 -> 16
        setcfg(24, 0);
        expect_frame("R3 divisor 24", 8'h3C, 0, 0, 1, 32.0);
        setcfg(23, 0);
        expect_frame("R3 divisor 23", 8'hC3, 0, 0, 1, 16.0);

        // R4 default divisor
        setcfg(0, 0);
        expect_frame("R4 divisor zero", 8'h5A, 0, 0, 1, 432.0);

        // R5 parity modes
        setcfg(32, 1);
        expect_frame("R5 even parity", 8'h17, 1, 0, 1, 32.0);
        setcfg(32, 2);
        expect_frame("R5 odd parity", 8'h17, 2, 0, 1, 32.0);

        // R6 parity mismatch, R7 low stop bit
        setcfg(32, 1);
        expect_frame("R6 even mismatch", 8'h6E, 1, 1, 1, 32.0);
        setcfg(32, 2);
        expect_frame("R6 odd mismatch", 8'h81, 2, 1, 1, 32.0);
        setcfg(32, 0);
        expect_frame("R7 stop low", 8'h92, 0, 0, 0, 32.0);
        setcfg(32, 2);
        expect_frame("R7 stop low with parity", 8'h4D, 2, 0, 0, 32.0);

        // R8 configuration changed mid-frame
        begin
            int v0;
            setcfg(32, 0);
            v0 = vcount;
            fork
                send(8'hB7, 0, 0, 1, 32.0);
                begin
                    repeat (96) @(negedge clk);
                    divisor = 16'd64; parity_en = 1'b1; parity_odd = 1'b1;
                end
            join
            chk(vcount == v0 + 1, "R8 valid count", vcount - v0, 1);
            chk(last_data == 8'hB7, "R8 data", last_data, 8'hB7);
            chk(last_err == 1'b0, "R8 error", last_err, 0);
        end

        // R9 glitched start
        begin
            int v0;
            setcfg(32, 0);
            v0 = vcount;
            rx_line = 1'b0;
            repeat (8) @(negedge clk);
            rx_line = 1'b1;
            repeat (400) @(negedge clk);
            chk(vcount == v0, "R9 glitch gives no valid", vcount - v0, 0);
            expect_frame("R9 frame after glitch", 8'h2B, 0, 0, 1, 32.0);
        end

        // R10 bit-rate mismatch
        setcfg(160, 0);
        for (int i = 0; i < 3; i++) begin
            logic [7:0] b = 8'($urandom);
            expect_frame("R10 sender 4% slow", b, 0, 0, 1, 160.0 * 1.04);
            expect_frame("R10 sender 4% fast", b ^ 8'h5A, 0, 0, 1, 160.0 * 0.96);
        end

        // random mix: R2 R3 R5 R6 R7
        for (int i = 0; i < 40; i++) begin
            int div  = 16 * (1 + int'($urandom % 4)) + int'($urandom % 5) - 2;
            int mode = int'($urandom % 3);
            bit flip = (($urandom % 5) == 0);
            bit stv  = (($urandom % 6) != 0);
            logic [7:0] b = 8'($urandom);
            if (div < 16) div = 16;
            setcfg(div, mode);
            expect_frame("R5 R6 R7 random frame", b, mode, flip, stv, real'(bit_clocks(div)));
        end

        // R11 pulse shape over the whole run
        chk(bad_err == 0, "R11 error without valid", bad_err, 0);
        chk(bad_pulse == 0, "R11 valid wider than one cycle", bad_pulse, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end
endmodule